// File: doc/BRIEF.md
# Ethernet Controller Command and Interrupt-Mask Registers

This block is the control register slice of a simple Ethernet controller. It sits on a byte-addressed register bus and holds two registers. The 8-bit command register starts a self-clearing software reset and enables the transmit and receive state machines. The 16-bit interrupt mask register gates the controller's interrupt status bits into a single interrupt line.

The transmit and receive datapaths are not part of this block. They appear only as plain handshake pins. A software reset raises a request that stays high until the datapath pulses a done input. The enable outputs go to the state machines, and those machines report back through active flags. A receive-ring empty flag also comes in. The command register reads back this live status, not the stored write value.

Reads are combinational from the address. Writes take effect at the clock edge on which the write strobe is sampled. The interrupt output is registered once.

Top module: `nic_ctrl_regs`

## Requirements
- R1: A read at byte address 0x37 returns the reset-in-progress flag on bit 4, the `rx_active` input on bit 3, the `tx_active` input on bit 2 and the `rx_buf_empty` input on bit 0. Bits 7 to 5 and bit 1 always read 0.
- R2: A write to 0x37 with bit 4 set, made while no reset is in progress, does two things from the next clock edge. It raises `sw_rst_req`, and it clears `tx_en` and `rx_en` whatever the other write bits hold.
- R3: `sw_rst_req` (and read bit 4) stays 1 until `sw_rst_done` is sampled high. It reads 0 from the following edge. `tx_en` and `rx_en` stay 0 for the whole reset.
- R4: Writes to 0x37 made while a reset is in progress are ignored.
- R5: A write to 0x37 with bit 4 clear loads bit 3 into `rx_en` at the next edge.
- R6: A write to 0x37 with bit 4 clear and bit 2 clear clears `tx_en`. With bit 2 set, it sets `tx_en` only if `tx_active` is 0 at that edge; otherwise `tx_en` keeps its value.
- R7: While `rst_n` is low, `tx_en`, `rx_en`, `sw_rst_req`, the mask and `irq` are all 0.
- R8: Address 0x3C holds mask bits 7:0 and address 0x3D holds mask bits 15:8. Both bytes read back as written. A software reset leaves the mask unchanged.
- R9: `irq` is 1 one clock edge after a cycle in which some bit is set in both `irq_status` and the mask. It is 0 one edge after a cycle with no such bit. Bit 15 is the system-error source and bit 14 is the timeout source.
- R10: Addresses other than 0x37, 0x3C and 0x3D read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low bus reset |
| wr_en | input | 1 | Write strobe for the current address |
| addr | input | 8 | Byte address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| sw_rst_req | output | 1 | High while a software reset is in progress |
| sw_rst_done | input | 1 | Datapath pulse marking reset completion |
| tx_en | output | 1 | Transmit state machine enable |
| rx_en | output | 1 | Receive state machine enable |
| tx_active | input | 1 | Transmit state machine is active |
| rx_active | input | 1 | Receive state machine is active |
| rx_buf_empty | input | 1 | Receive ring holds no packets |
| irq_status | input | 16 | Raw interrupt status bits |
| irq | output | 1 | Registered masked interrupt |

## Verification
Read data is due in the same cycle as the address. The bench checks it one time unit after driving the address at a falling edge.

Register results are due one rising edge after their cause. These are the enables, `sw_rst_req`, the mask and `irq`. The bench drives each stimulus at a falling edge and samples at the next falling edge.

For the interrupt, the bench also samples just after the status changes, before the edge, and confirms the output has not moved yet. It then sweeps every pairing of a single mask bit with a single status bit.

// File: rtl/nic_regs_pkg.sv
package nic_regs_pkg;
  localparam int CMD_RST_BIT   = 4;
  localparam int CMD_RXEN_BIT  = 3;
  localparam int CMD_TXEN_BIT  = 2;
  localparam int CMD_EMPTY_BIT = 0;
  localparam int BYTE_W        = 8;
endpackage

// File: rtl/nic_cmd_ctrl.sv
module nic_cmd_ctrl
  import nic_regs_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CMD_ADDR = 'h37
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              sw_rst_done,
  input  logic              tx_active,
  output logic              rst_busy,
  output logic              tx_en,
  output logic              rx_en
);
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

  logic cmd_wr;
  assign cmd_wr = wr_en && (addr == CMD_A);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_busy <= 1'b0;
      tx_en    <= 1'b0;
      rx_en    <= 1'b0;
    end else if (rst_busy) begin
      tx_en <= 1'b0;
      rx_en <= 1'b0;
      if (sw_rst_done) rst_busy <= 1'b0;
    end else if (cmd_wr) begin
      if (wdata[CMD_RST_BIT]) begin
        rst_busy <= 1'b1;
        tx_en    <= 1'b0;
        rx_en    <= 1'b0;
      end else begin
        rx_en <= wdata[CMD_RXEN_BIT];
        if (!wdata[CMD_TXEN_BIT]) tx_en <= 1'b0;
        else if (!tx_active)      tx_en <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/nic_irq_mask.sv
module nic_irq_mask
  import nic_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MASK_W    = 16,
  parameter int MASK_ADDR = 'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic [MASK_W-1:0] irq_status,
  output logic [MASK_W-1:0] mask_q,
  output logic              irq
);
  localparam int MASK_BYTES = MASK_W / BYTE_W;

  for (genvar b = 0; b < MASK_BYTES; b++) begin : g_byte
    localparam logic [ADDR_W-1:0] BYTE_A = ADDR_W'(MASK_ADDR + b);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                         mask_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (wr_en && addr == BYTE_A)   mask_q[b*BYTE_W +: BYTE_W] <= wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq <= 1'b0;
    else        irq <= |(irq_status & mask_q);
  end
endmodule

// File: rtl/nic_ctrl_regs.sv
module nic_ctrl_regs
  import nic_regs_pkg::*;
#(
  parameter int ADDR_W    = 8,
  parameter int MASK_W    = 16,
  parameter int CMD_ADDR  = 'h37,
  parameter int MASK_ADDR = 'h3C
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        wdata,
  output logic [7:0]        rdata,
  output logic              sw_rst_req,
  input  logic              sw_rst_done,
  output logic              tx_en,
  output logic              rx_en,
  input  logic              tx_active,
  input  logic              rx_active,
  input  logic              rx_buf_empty,
  input  logic [MASK_W-1:0] irq_status,
  output logic              irq
);
  localparam int MASK_BYTES = MASK_W / BYTE_W;
  localparam logic [ADDR_W-1:0] CMD_A = ADDR_W'(CMD_ADDR);

  logic              rst_busy;
  logic [MASK_W-1:0] mask_q;

  nic_cmd_ctrl #(.ADDR_W(ADDR_W), .CMD_ADDR(CMD_ADDR)) u_cmd (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .sw_rst_done(sw_rst_done), .tx_active(tx_active),
    .rst_busy(rst_busy), .tx_en(tx_en), .rx_en(rx_en)
  );

  nic_irq_mask #(.ADDR_W(ADDR_W), .MASK_W(MASK_W), .MASK_ADDR(MASK_ADDR)) u_irq (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .irq_status(irq_status), .mask_q(mask_q), .irq(irq)
  );

  assign sw_rst_req = rst_busy;

  always_comb begin
    rdata = '0;
    if (addr == CMD_A) begin
      rdata[CMD_RST_BIT]   = rst_busy;
      rdata[CMD_RXEN_BIT]  = rx_active;
      rdata[CMD_TXEN_BIT]  = tx_active;
      rdata[CMD_EMPTY_BIT] = rx_buf_empty;
    end
    for (int b = 0; b < MASK_BYTES; b++) begin
      if (addr == ADDR_W'(MASK_ADDR + b)) rdata = mask_q[b*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/nic_ctrl_regs_chk.sv
module nic_ctrl_regs_chk #(
  parameter int ADDR_W = 8,
  parameter int MASK_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] addr,
  input logic              sw_rst_req,
  input logic              sw_rst_done,
  input logic              tx_en,
  input logic              rx_en,
  input logic              tx_active,
  input logic [MASK_W-1:0] irq_status,
  input logic [MASK_W-1:0] mask_q,
  input logic              irq
);
  // R3: the reset request holds until completion is reported
  assert_rst_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req && !sw_rst_done |=> sw_rst_req);

  // R3: completion ends the reset on the next edge
  assert_rst_end_R3: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req && sw_rst_done |=> !sw_rst_req);

  // R2: enables are off throughout a software reset
  assert_en_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sw_rst_req |-> !tx_en && !rx_en);

  // R6: transmit enable only rises when the transmitter was idle
  assert_tx_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |-> $past(!tx_active));

  // R8: mask changes only through a bus write
  assert_mask_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

  // R9: an interrupt needs a status bit in the previous cycle
  assert_irq_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> $past(|irq_status));
endmodule

bind nic_ctrl_regs nic_ctrl_regs_chk #(.ADDR_W(ADDR_W), .MASK_W(MASK_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
  .sw_rst_req(sw_rst_req), .sw_rst_done(sw_rst_done),
  .tx_en(tx_en), .rx_en(rx_en), .tx_active(tx_active),
  .irq_status(irq_status), .mask_q(mask_q), .irq(irq)
);

// File: tb/test_nic_ctrl_regs.sv
module test_nic_ctrl_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic        sw_rst_req;
  logic        sw_rst_done = 1'b0;
  logic        tx_en, rx_en;
  logic        tx_active = 1'b0;
  logic        rx_active = 1'b0;
  logic        rx_buf_empty = 1'b1;
  logic [15:0] irq_status = '0;
  logic        irq;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  always #2 clk = ~clk;

  nic_ctrl_regs i_nic_ctrl_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .sw_rst_req(sw_rst_req), .sw_rst_done(sw_rst_done),
    .tx_en(tx_en), .rx_en(rx_en), .tx_active(tx_active), .rx_active(rx_active),
    .rx_buf_empty(rx_buf_empty), .irq_status(irq_status), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic read_chk(input string tag, input logic [7:0] a, input logic [7:0] exp);
    addr = a;
    #1;
    check(tag, {24'h0, rdata}, {24'h0, exp});
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: state during bus reset
    check("R7 tx_en", {31'h0, tx_en}, 0);
    check("R7 rx_en", {31'h0, rx_en}, 0);
    check("R7 req", {31'h0, sw_rst_req}, 0);
    check("R7 irq", {31'h0, irq}, 0);
    read_chk("R7 mask lo", 8'h3C, 8'h00);
    read_chk("R7 mask hi", 8'h3D, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: status readback over all input combinations
    for (int k = 0; k < 8; k++) begin
      rx_active = k[2]; tx_active = k[1]; rx_buf_empty = k[0];
      read_chk("R1 cmd readback", 8'h37, {4'b0, k[2], k[1], 1'b0, k[0]});
    end
    rx_active = 0; tx_active = 0; rx_buf_empty = 1;

    // R5 / R6: enables
    bus_write(8'h37, 8'h08);
    check("R5 rx_en set", {31'h0, rx_en}, 1);
    check("R6 tx_en untouched", {31'h0, tx_en}, 0);
    bus_write(8'h37, 8'h04);
    check("R5 rx_en cleared", {31'h0, rx_en}, 0);
    check("R6 tx_en idle set", {31'h0, tx_en}, 1);
    bus_write(8'h37, 8'h00);
    check("R6 tx_en cleared", {31'h0, tx_en}, 0);
    tx_active = 1;
    bus_write(8'h37, 8'h0C);
    check("R6 tx_en blocked busy", {31'h0, tx_en}, 0);
    check("R5 rx_en with busy tx", {31'h0, rx_en}, 1);
    tx_active = 0;
    bus_write(8'h37, 8'h0C);
    check("R6 tx_en after idle", {31'h0, tx_en}, 1);

    // R1: reserved and read-only bits ignored on write
    bus_write(8'h37, 8'hE3);
    check("R1 reserved write tx", {31'h0, tx_en}, 0);
    check("R1 reserved write req", {31'h0, sw_rst_req}, 0);
    read_chk("R1 reserved read", 8'h37, 8'h01);

    // R10: other addresses
    bus_write(8'h37, 8'h0C);
    bus_write(8'h38, 8'hFF);
    bus_write(8'h3E, 8'hFF);
    check("R10 tx_en kept", {31'h0, tx_en}, 1);
    check("R10 no reset", {31'h0, sw_rst_req}, 0);
    read_chk("R10 read 38", 8'h38, 8'h00);
    read_chk("R10 read 3E", 8'h3E, 8'h00);
    read_chk("R10 mask lo intact", 8'h3C, 8'h00);

    // R8: mask bytes, then R2/R3/R4 software reset keeps mask
    bus_write(8'h3D, 8'hC0);
    bus_write(8'h3C, 8'h5A);
    read_chk("R8 mask hi", 8'h3D, 8'hC0);
    read_chk("R8 mask lo", 8'h3C, 8'h5A);
    bus_write(8'h37, 8'h1C);
    check("R2 req raised", {31'h0, sw_rst_req}, 1);
    check("R2 tx_en cleared", {31'h0, tx_en}, 0);
    check("R2 rx_en cleared", {31'h0, rx_en}, 0);
    read_chk("R3 busy readback", 8'h37, 8'h11);
    repeat (5) @(negedge clk);
    check("R3 req held", {31'h0, sw_rst_req}, 1);
    bus_write(8'h37, 8'h0C);
    check("R4 tx_en ignored", {31'h0, tx_en}, 0);
    check("R4 rx_en ignored", {31'h0, rx_en}, 0);
    @(negedge clk); sw_rst_done = 1;
    @(negedge clk); sw_rst_done = 0;
    check("R3 req cleared", {31'h0, sw_rst_req}, 0);
    read_chk("R3 idle readback", 8'h37, 8'h01);
    read_chk("R8 mask hi kept", 8'h3D, 8'hC0);
    read_chk("R8 mask lo kept", 8'h3C, 8'h5A);

    // R9: one-hot mask against one-hot status
    for (int i = 0; i < 16; i++) begin
      bus_write(8'h3C, 8'(16'(1) << i));
      bus_write(8'h3D, 8'((16'(1) << i) >> 8));
      read_chk("R8 sweep lo", 8'h3C, 8'(16'(1) << i));
      read_chk("R8 sweep hi", 8'h3D, 8'((16'(1) << i) >> 8));
      for (int j = 0; j < 16; j++) begin
        @(negedge clk);
        irq_status = 16'(1) << j;
        #1;
        check("R9 irq not early", {31'h0, irq}, 0);
        @(negedge clk);
        check("R9 irq masked", {31'h0, irq}, {31'h0, i == j});
        irq_status = '0;
        @(negedge clk);
        check("R9 irq drops", {31'h0, irq}, 0);
      end
    end

    // R7: bus reset clears mask and enables
    bus_write(8'h37, 8'h0C);
    rst_n = 0;
    #1;
    check("R7 tx_en reset", {31'h0, tx_en}, 0);
    check("R7 rx_en reset", {31'h0, rx_en}, 0);
    read_chk("R7 mask cleared", 8'h3D, 8'h00);
    rst_n = 1;

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule